// File: doc/BRIEF.md
# SIR Receive Frame Unwrapper

This block sits behind a SIR infrared byte receiver and turns the wrapped, byte-stuffed frames it delivers into bare packets. The filter waits for a start flag and then forwards the address, control, information and check bytes. Idle fill, the start flag, the end flag and escape introducers never reach the output. The 16-bit check sequence at the tail of each frame is passed on untouched, so a later stage can verify it.

Packets leave as a byte stream with a valid strobe and a last marker. When a frame closes, a two-bit error word is presented for one cycle. A live count of the bytes forwarded in the current packet is always visible. A programmable limit caps how many bytes one packet may forward. The two fixed flag codes are also readable as one 16-bit constant word.

Top module: `sir_unwrap`

## Requirements
- R1: After reset `out_valid`, `out_last` and `stat_valid` are low and `byte_cnt` is 0. `flag_word` always reads 16'hC1C0: the start flag 0xC0 in bits [7:0] and the end flag 0xC1 in bits [15:8].
- R2: While no frame is open, every input byte is discarded and produces neither output nor status. This includes 0xFF fill and 0x7D.
- R3: The byte 0xC0 opens a frame and 0xC1 closes it. Neither flag is forwarded. The bytes between them, including the two trailing check bytes, are forwarded in arrival order.
- R4: Inside a frame, a 0x7D byte is dropped and the byte after it is forwarded XORed with 0x20.
- R5: Output lags by one payload byte: a byte is emitted when the next payload byte or the closing flag arrives. The final byte of a packet carries `out_last`, which is high in the same cycle as `stat_valid`. In `stat_err`, bit 0 flags a length error and bit 1 flags a missing end flag.
- R6: A 0xC0 that arrives while a frame is open closes the current packet with `stat_err[1]`=1 and at once opens a new packet.
- R7: `byte_cnt` counts the bytes forwarded for the current packet. It changes in the cycle after each accepted byte and returns to 0 when a start flag arrives.
- R8: Once `max_len` bytes have been forwarded, further payload bytes of that frame are dropped and not counted, and the closing status has `stat_err[0]`=1. A frame of exactly `max_len` bytes has no length error.
- R9: A frame with no payload (0xC0 directly followed by 0xC1) yields one status pulse with `stat_err`=0 and no output byte.
- R10: Cycles with `in_valid` low change neither the output nor the frame state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Received byte strobe |
| in_byte | input | 8 | Received byte |
| max_len | input | 12 | Largest number of bytes forwarded per packet |
| out_valid | output | 1 | Forwarded byte strobe |
| out_byte | output | 8 | Forwarded byte |
| out_last | output | 1 | Marks the final byte of a packet |
| stat_valid | output | 1 | End-of-packet status strobe |
| stat_err | output | 2 | [0] length error, [1] missing end flag |
| byte_cnt | output | 12 | Bytes forwarded in the current packet |
| flag_word | output | 16 | Fixed flag codes, end flag high byte |

## Verification
The assertions take for granted that `in_valid` and `in_byte` are clean after reset. They also assume `max_len` is changed only while no frame is open, so a count never has to shrink mid-packet. The stimulus drives inputs at the falling edge, holds `in_valid` low throughout reset, and reprograms the limit only between frames. Every frame closes with a flag or a resynchronising start flag before the next scenario's checks are made.

// File: rtl/sir_unwrap.sv
module sir_unwrap #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic [LEN_W-1:0] max_len,
  output logic             out_valid,
  output logic [7:0]       out_byte,
  output logic             out_last,
  output logic             stat_valid,
  output logic [1:0]       stat_err,
  output logic [LEN_W-1:0] byte_cnt,
  output logic [15:0]      flag_word
);
  localparam logic [7:0] SOF = 8'hC0;
  localparam logic [7:0] EOF = 8'hC1;
  localparam logic [7:0] ESC = 8'h7D;

  logic             in_frame, esc, hold_vld, len_err;
  logic [7:0]       hold_byte;
  logic [LEN_W-1:0] cnt;

  wire is_sof  = in_valid && in_byte == SOF;
  wire is_eof  = in_valid && in_byte == EOF;
  wire close   = in_frame && (is_sof || is_eof);
  wire payload = in_valid && in_frame && !is_sof && !is_eof && (esc || in_byte != ESC);
  wire [7:0] data = esc ? (in_byte ^ 8'h20) : in_byte;

  assign flag_word = {EOF, SOF};
  assign byte_cnt  = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame <= 1'b0; esc <= 1'b0; hold_vld <= 1'b0; len_err <= 1'b0;
      hold_byte <= '0; cnt <= '0;
      out_valid <= 1'b0; out_byte <= '0; out_last <= 1'b0;
      stat_valid <= 1'b0; stat_err <= '0;
    end else begin
      out_valid  <= 1'b0;
      out_last   <= 1'b0;
      stat_valid <= 1'b0;
      if (close) begin
        out_valid  <= hold_vld;
        out_byte   <= hold_byte;
        out_last   <= hold_vld;
        stat_valid <= 1'b1;
        stat_err   <= {is_sof, len_err};
        hold_vld   <= 1'b0;
      end
      if (is_sof) begin
        in_frame <= 1'b1;
        esc      <= 1'b0;
        cnt      <= '0;
        len_err  <= 1'b0;
        hold_vld <= 1'b0;
      end else if (is_eof) begin
        in_frame <= 1'b0;
        esc      <= 1'b0;
      end else if (in_valid && in_frame) begin
        esc <= !esc && in_byte == ESC;
        if (payload) begin
          if (cnt < max_len) begin
            out_valid <= hold_vld;
            out_byte  <= hold_byte;
            hold_byte <= data;
            hold_vld  <= 1'b1;
            cnt       <= cnt + 1'b1;
          end else begin
            len_err <= 1'b1;
          end
        end
      end
    end
  end

  AST_LAST_HAS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> stat_valid && out_valid);  // R5
  AST_OUT_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));  // R10
  AST_STATUS_ON_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> $past(in_valid) && ($past(in_byte) == SOF || $past(in_byte) == EOF));  // R3
  AST_NOEND_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid && stat_err[1] |-> $past(in_byte) == SOF);  // R6
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != $past(cnt) |-> cnt == '0 || cnt == $past(cnt) + 1'b1);  // R7
  AST_NO_OUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_frame) |-> !out_valid && !stat_valid);  // R2
endmodule

// File: tb/sir_unwrap_tb.sv
`timescale 1ns/1ps
module sir_unwrap_tb;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic [11:0] max_len = 12'd4095;
  logic out_valid, out_last, stat_valid;
  logic [7:0] out_byte;
  logic [1:0] stat_err;
  logic [11:0] byte_cnt;
  logic [15:0] flag_word;

  int nchk = 0, nerr = 0;
  logic [7:0] got[$];
  bit got_last[$];
  logic [1:0] got_err[$];
  bit stat_mismatch = 0;
  logic [7:0] exp_b[$];
  bit exp_l[$];

  sir_unwrap u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .max_len(max_len), .out_valid(out_valid), .out_byte(out_byte), .out_last(out_last),
    .stat_valid(stat_valid), .stat_err(stat_err), .byte_cnt(byte_cnt), .flag_word(flag_word));

  always #2.5 clk = ~clk;

  always @(negedge clk) if (rst_n) begin
    if (out_valid) begin got.push_back(out_byte); got_last.push_back(out_last); end
    if (stat_valid) got_err.push_back(stat_err);
    if (out_last != stat_valid && out_valid) stat_mismatch = 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    in_valid = 1'b1; in_byte = b;
    @(negedge clk);
    in_valid = 1'b0; in_byte = 8'h00;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_cap();
    got.delete(); got_last.delete(); got_err.delete(); exp_b.delete(); exp_l.delete();
    stat_mismatch = 0;
  endtask

  task automatic check_stream(input string req);
    chk(got.size() == exp_b.size(), {req, " byte count"}, got.size(), exp_b.size());
    if (got.size() == exp_b.size())
      foreach (exp_b[i]) begin
        chk(got[i] == exp_b[i], {req, " byte"}, got[i], exp_b[i]);
        chk(got_last[i] == exp_l[i], {req, " last"}, got_last[i], exp_l[i]);
      end
    chk(!stat_mismatch, "R5 last with status", stat_mismatch, 0);
  endtask

  task automatic t_reset();
    chk(!out_valid && !out_last && !stat_valid, "R1 outputs idle", {out_valid, out_last, stat_valid}, 0);
    chk(byte_cnt == 0, "R1 count", byte_cnt, 0);
    chk(flag_word == 16'hC1C0, "R1 flag word", flag_word, 16'hC1C0);
  endtask

  task automatic t_basic();
    clear_cap();
    put(8'hFF); put(8'hFF); put(8'hC0);
    put(8'h11); put(8'h22); put(8'h33); put(8'h44);
    chk(byte_cnt == 4, "R7 live count", byte_cnt, 4);
    put(8'hC1); idle(2);
    exp_b = '{8'h11, 8'h22, 8'h33, 8'h44}; exp_l = '{0, 0, 0, 1};
    check_stream("R3");
    chk(got_err.size() == 1 && got_err[0] == 2'b00, "R5 status ok", got_err.size(), 1);
    chk(byte_cnt == 4, "R7 held count", byte_cnt, 4);
  endtask

  task automatic t_outside();
    clear_cap();
    put(8'h55); put(8'h7D); put(8'hFF); put(8'h12); put(8'hC1); idle(2);
    chk(got.size() == 0, "R2 no bytes outside frame", got.size(), 0);
    chk(got_err.size() == 0, "R2 no status outside frame", got_err.size(), 0);
  endtask

  task automatic t_escape();
    clear_cap();
    put(8'hC0); put(8'h7D); put(8'hE0); put(8'h7D); put(8'h5D);
    put(8'h7D); put(8'hE1); put(8'hAA); put(8'hC1); idle(2);
    exp_b = '{8'hC0, 8'h7D, 8'hC1, 8'hAA}; exp_l = '{0, 0, 0, 1};
    check_stream("R4");
  endtask

  task automatic t_noend();
    clear_cap();
    put(8'hC0); put(8'h01); put(8'h02); put(8'hC0);
    chk(byte_cnt == 0, "R7 reset at start flag", byte_cnt, 0);
    put(8'h03); put(8'hC1); idle(2);
    exp_b = '{8'h01, 8'h02, 8'h03}; exp_l = '{0, 1, 1};
    check_stream("R6");
    chk(got_err.size() == 2, "R6 two statuses", got_err.size(), 2);
    if (got_err.size() == 2) begin
      chk(got_err[0] == 2'b10, "R6 missing end flagged", got_err[0], 2);
      chk(got_err[1] == 2'b00, "R6 resync clean", got_err[1], 0);
    end
  endtask

  task automatic t_length(input int lim, input int n);
    clear_cap();
    max_len = 12'(lim);
    put(8'hC0);
    for (int i = 1; i <= n; i++) put(8'(i));
    chk(byte_cnt == 12'(lim < n ? lim : n), "R8 count capped", byte_cnt, lim < n ? lim : n);
    put(8'hC1); idle(2);
    for (int i = 1; i <= (lim < n ? lim : n); i++) begin
      exp_b.push_back(8'(i)); exp_l.push_back(i == (lim < n ? lim : n));
    end
    check_stream("R8");
    chk(got_err.size() == 1 && got_err[0] == {1'b0, n > lim}, "R8 length flag",
        got_err.size() ? got_err[0] : 3, n > lim);
    max_len = 12'd4095;
  endtask

  task automatic t_empty();
    clear_cap();
    put(8'hC0); put(8'hC1); idle(2);
    chk(got.size() == 0, "R9 no byte", got.size(), 0);
    chk(got_err.size() == 1 && got_err[0] == 2'b00, "R9 one clean status", got_err.size(), 1);
  endtask

  task automatic t_gaps();
    clear_cap();
    put(8'hC0); idle(3); put(8'h9A); idle(5);
    chk(got.size() == 0, "R5 one byte lag", got.size(), 0);
    put(8'h9B); idle(4);
    chk(got.size() == 1 && got[0] == 8'h9A, "R10 gap keeps frame", got.size(), 1);
    put(8'hC1); idle(2);
    exp_b = '{8'h9A, 8'h9B}; exp_l = '{0, 1};
    check_stream("R10");
  endtask

  initial begin
    #(5.0 * 200000);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end

  initial begin
    idle(4);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_basic();
    t_outside();
    t_escape();
    t_noend();
    t_length(3, 5);
    t_length(2, 2);
    t_empty();
    t_gaps();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule